// File: doc/BRIEF.md
# Receive Descriptor Chain Walker

This block follows a chain of receive descriptors kept in system memory on behalf of a network receiver. Each descriptor holds a link word that points to the next descriptor and an in-use word that the walker clears to give a filled descriptor back to the host. Bit 0 of a link word marks the end of the chain. The walker reads and writes memory through a simple master port that carries one access at a time.

When a packet arrives, the walker decides whether it can be stored and reports accept or drop. After the buffer logic signals that the payload is stored, the walker reads the current descriptor's link. If the link is valid, the walker releases the descriptor and moves on. If the link is end-of-chain, the walker keeps the descriptor and raises the exhausted flag. At the next arrival it reads the link again, so the host can extend the chain in the meantime. Only then is the held descriptor released.

The walker also raises the packet-received and chain-exhausted flags and keeps a receive sequence count. The host clears the flags by writing a one to them. A load strobe seeds the current pointer and the sequence count while the walker is idle.

Top module: `rx_desc_walker`

## Requirements
- R1: After synchronous reset, `cur_ptr`, `last_link` and `seq_count` are 0, both flags are low, and `busy`, `mem_req` and `dec_valid` are low.
- R2: A descriptor access uses byte address {`upper_addr`, pointer with bit 0 forced to 0} plus a field offset. The link field offset is 10 bytes in 16-bit mode and 20 bytes in 32-bit mode (`wide_mode`=1). The in-use field offset is 12 and 24 bytes respectively. The stored pointer keeps its bit 0.
- R3: After `pkt_stored`, the link field of the current descriptor is read and its low 16 bits go into `last_link`. If bit 0 is 1, `irq_exh` is set, `cur_ptr` does not change and no write is issued.
- R4: If the link read after `pkt_stored` has bit 0 clear, the walker writes 0 to the in-use field, copies `last_link` into `cur_ptr` and sets `irq_rx`.
- R5: On `pkt_arrive` with `last_link` bit 0 set, the link of `cur_ptr` is read again into `last_link`. If bit 0 is still set, `dec_valid` pulses with `dec_accept`=0, no write is issued and `seq_count` is unchanged.
- R6: If that second read finds bit 0 clear, the walker writes 0 to the held descriptor's in-use field, sets `irq_rx` and moves `cur_ptr` to the new link. It then pulses `dec_valid` with `dec_accept`=1.
- R7: Every write drives `mem_wdata` as all 32 bits zero, so in 32-bit mode the upper half of the long word is zero as well.
- R8: Each stored packet adds 1 to bits [7:0] of `seq_count`, modulo 256, while bits [15:8] are kept. This holds whether or not the chain was exhausted.
- R9: `mem_req` stays high with a stable address until `mem_done`, and only one access is outstanding at a time. `busy` is high from `pkt_arrive` until the walk for that packet completes, including the wait for `pkt_stored`.
- R10: A 1 on `irq_clr[0]` clears `irq_rx` and a 1 on `irq_clr[1]` clears `irq_exh`. When a flag is set and cleared in the same cycle, the set wins.
- R11: `cfg_load` while idle loads `cur_ptr` from `cfg_ptr`, `last_link` from `cfg_ptr` with bit 0 cleared, and `seq_count` from `cfg_seq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wide_mode | input | 1 | 1 selects 32-bit descriptor layout; sampled at `pkt_arrive` |
| upper_addr | input | 16 | Upper half of every descriptor address |
| cfg_load | input | 1 | Seeds pointer, link and sequence count while idle |
| cfg_ptr | input | 16 | Pointer value loaded by `cfg_load` |
| cfg_seq | input | 16 | Sequence value loaded by `cfg_load` |
| irq_clr | input | 2 | Write-one-to-clear: bit 0 for `irq_rx`, bit 1 for `irq_exh` |
| pkt_arrive | input | 1 | One-cycle pulse when a packet starts |
| pkt_stored | input | 1 | One-cycle pulse when the payload has been written |
| dec_valid | output | 1 | One-cycle pulse carrying the accept or drop decision |
| dec_accept | output | 1 | 1 = store the packet, 0 = drop it |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory access request, held until `mem_done` |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_done` |
| mem_done | input | 1 | Access completion pulse |
| cur_ptr | output | 16 | Current descriptor pointer |
| last_link | output | 16 | Last link word read |
| seq_count | output | 16 | Receive sequence count |
| irq_rx | output | 1 | Packet-received flag |
| irq_exh | output | 1 | Chain-exhausted flag |

## Verification
The bench builds the walker with its default values: 16-bit fields, link at word 5, in-use at word 6 and an 8-bit wrapping field inside the sequence count. With these values both descriptor layouts fit in a 512-byte model memory, so a nonzero upper address half can be checked next to the masked low pointer. Seeding the count at 0x12FF makes the low-byte wrap happen on the first packet. The hold, drop, host-append and release sequence is driven by editing the model memory between arrivals.

// File: rtl/rxdw_pkg.sv
package rxdw_pkg;

    parameter int unsigned PTR_W = 16;
    parameter int unsigned SEQ_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_REREAD     = 3'd1,
        ST_RELEASE    = 3'd2,
        ST_WAIT_STORE = 3'd3,
        ST_LINK_RD    = 3'd4,
        ST_INUSE_WR   = 3'd5
    } walk_state_e;

    typedef struct packed {
        walk_state_e      state;
        logic             wide;
        logic [PTR_W-1:0] cur;
        logic [PTR_W-1:0] link;
        logic [SEQ_W-1:0] seq;
        logic             irq_rx;
        logic             irq_exh;
        logic             dec_valid;
        logic             dec_accept;
    } walk_regs_t;

endpackage

// File: rtl/rxdw_addr_gen.sv
module rxdw_addr_gen #(
    parameter int unsigned PTR_W      = 16,
    parameter int unsigned LINK_WORD  = 5,
    parameter int unsigned INUSE_WORD = 6
) (
    input  logic [PTR_W-1:0]   upper_i,
    input  logic [PTR_W-1:0]   ptr_i,
    input  logic               wide_i,
    input  logic               sel_inuse_i,
    output logic [2*PTR_W-1:0] addr_o
);
    localparam int unsigned AW         = 2 * PTR_W;
    localparam int unsigned FIELD_B    = PTR_W / 8;
    localparam logic [AW-1:0] LINK_N   = AW'(LINK_WORD * FIELD_B);
    localparam logic [AW-1:0] LINK_W   = AW'(LINK_WORD * FIELD_B * 2);
    localparam logic [AW-1:0] INUSE_N  = AW'(INUSE_WORD * FIELD_B);
    localparam logic [AW-1:0] INUSE_W  = AW'(INUSE_WORD * FIELD_B * 2);

    logic [AW-1:0] base;
    logic [AW-1:0] offset;

    // the end-of-chain bit never reaches the address
    assign base = {upper_i, ptr_i[PTR_W-1:1], 1'b0};

    always_comb begin
        if (sel_inuse_i) offset = wide_i ? INUSE_W : INUSE_N;
        else             offset = wide_i ? LINK_W  : LINK_N;
    end

    assign addr_o = base + offset;
endmodule

// File: rtl/rxdw_seq_bump.sv
module rxdw_seq_bump #(
    parameter int unsigned SEQ_W = 16,
    parameter int unsigned LOW_W = 8
) (
    input  logic [SEQ_W-1:0] seq_i,
    output logic [SEQ_W-1:0] seq_o
);
    generate
        if (LOW_W >= SEQ_W) begin : g_whole
            assign seq_o = seq_i + 1'b1;
        end else begin : g_split
            logic [LOW_W-1:0] low_next;
            assign low_next = seq_i[LOW_W-1:0] + 1'b1;
            assign seq_o    = {seq_i[SEQ_W-1:LOW_W], low_next};
        end
    endgenerate
endmodule

// File: rtl/rx_desc_walker.sv
module rx_desc_walker
    import rxdw_pkg::*;
#(
    parameter int unsigned LINK_WORD  = 5,
    parameter int unsigned INUSE_WORD = 6,
    parameter int unsigned SEQ_LOW_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wide_mode,
    input  logic [PTR_W-1:0]   upper_addr,
    input  logic               cfg_load,
    input  logic [PTR_W-1:0]   cfg_ptr,
    input  logic [SEQ_W-1:0]   cfg_seq,
    input  logic [1:0]         irq_clr,
    input  logic               pkt_arrive,
    input  logic               pkt_stored,
    output logic               dec_valid,
    output logic               dec_accept,
    output logic               busy,
    output logic               mem_req,
    output logic               mem_we,
    output logic [2*PTR_W-1:0] mem_addr,
    output logic [2*PTR_W-1:0] mem_wdata,
    input  logic [2*PTR_W-1:0] mem_rdata,
    input  logic               mem_done,
    output logic [PTR_W-1:0]   cur_ptr,
    output logic [PTR_W-1:0]   last_link,
    output logic [SEQ_W-1:0]   seq_count,
    output logic               irq_rx,
    output logic               irq_exh
);
    localparam logic [PTR_W-1:0] RELEASE_WORD = '0;
    localparam int unsigned      KEEP_LO      = (SEQ_LOW_W < SEQ_W) ? SEQ_LOW_W : 0;

    walk_regs_t r_q, r_d;
    logic [SEQ_W-1:0] seq_next;
    logic [PTR_W-1:0] rd_word;
    logic [PTR_W-1:0] unused_rd_hi;
    logic             set_rx, set_exh;

    assign rd_word      = mem_rdata[PTR_W-1:0];
    assign unused_rd_hi = mem_rdata[2*PTR_W-1:PTR_W];

    rxdw_addr_gen #(
        .PTR_W      (PTR_W),
        .LINK_WORD  (LINK_WORD),
        .INUSE_WORD (INUSE_WORD)
    ) i_addr (
        .upper_i     (upper_addr),
        .ptr_i       (r_q.cur),
        .wide_i      (r_q.wide),
        .sel_inuse_i (mem_we),
        .addr_o      (mem_addr)
    );

    rxdw_seq_bump #(
        .SEQ_W (SEQ_W),
        .LOW_W (SEQ_LOW_W)
    ) i_seq (
        .seq_i (r_q.seq),
        .seq_o (seq_next)
    );

    always_comb begin
        r_d           = r_q;
        r_d.dec_valid = 1'b0;
        set_rx        = 1'b0;
        set_exh       = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (pkt_arrive) begin
                    r_d.wide = wide_mode;
                    if (r_q.link[0]) begin
                        r_d.state = ST_REREAD;
                    end else begin
                        r_d.state      = ST_WAIT_STORE;
                        r_d.dec_valid  = 1'b1;
                        r_d.dec_accept = 1'b1;
                    end
                end else if (cfg_load) begin
                    r_d.cur  = cfg_ptr;
                    r_d.link = {cfg_ptr[PTR_W-1:1], 1'b0};
                    r_d.seq  = cfg_seq;
                end
            end
            ST_REREAD: begin
                if (mem_done) begin
                    r_d.link = rd_word;
                    if (rd_word[0]) begin
                        r_d.state      = ST_IDLE;
                        r_d.dec_valid  = 1'b1;
                        r_d.dec_accept = 1'b0;
                    end else begin
                        r_d.state = ST_RELEASE;
                    end
                end
            end
            ST_RELEASE: begin
                if (mem_done) begin
                    r_d.cur        = r_q.link;
                    set_rx         = 1'b1;
                    r_d.state      = ST_WAIT_STORE;
                    r_d.dec_valid  = 1'b1;
                    r_d.dec_accept = 1'b1;
                end
            end
            ST_WAIT_STORE: begin
                if (pkt_stored) r_d.state = ST_LINK_RD;
            end
            ST_LINK_RD: begin
                if (mem_done) begin
                    r_d.link = rd_word;
                    r_d.seq  = seq_next;
                    if (rd_word[0]) begin
                        set_exh   = 1'b1;
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.state = ST_INUSE_WR;
                    end
                end
            end
            ST_INUSE_WR: begin
                if (mem_done) begin
                    r_d.cur   = r_q.link;
                    set_rx    = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
        r_d.irq_rx  = (r_q.irq_rx  & ~irq_clr[0]) | set_rx;
        r_d.irq_exh = (r_q.irq_exh & ~irq_clr[1]) | set_exh;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign mem_req    = (r_q.state == ST_REREAD) || (r_q.state == ST_RELEASE) ||
                        (r_q.state == ST_LINK_RD) || (r_q.state == ST_INUSE_WR);
    assign mem_we     = (r_q.state == ST_RELEASE) || (r_q.state == ST_INUSE_WR);
    assign mem_wdata  = {{PTR_W{1'b0}}, RELEASE_WORD};
    assign busy       = (r_q.state != ST_IDLE);
    assign dec_valid  = r_q.dec_valid;
    assign dec_accept = r_q.dec_accept;
    assign cur_ptr    = r_q.cur;
    assign last_link  = r_q.link;
    assign seq_count  = r_q.seq;
    assign irq_rx     = r_q.irq_rx;
    assign irq_exh    = r_q.irq_exh;

    // R9: a pending access keeps its request and address until done
    assert_req_held_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr)));

    // R9: memory traffic only happens inside a walk
    assert_req_in_walk_R9: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    // R5: a drop is only reported while the chain end is still marked
    assert_drop_on_eol_R5: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !dec_accept) |-> last_link[0]);

    // R3: the exhausted flag rises only with an end-marked link in hand
    assert_exh_on_eol_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_exh) |-> last_link[0]);

    // R4 / R6: the pointer moves only together with a received-packet flag
    assert_move_flags_rx_R4: assert property (@(posedge clk) disable iff (rst)
        !cfg_load |=> ($stable(cur_ptr) || irq_rx));

    // R7: writes never carry anything but zero
    assert_write_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_wdata == '0));

    generate
        if (KEEP_LO != 0) begin : g_seq_chk
            // R8: the upper part of the sequence count is untouched by packets
            assert_seq_high_kept_R8: assert property (@(posedge clk) disable iff (rst)
                !cfg_load |=> (seq_count[SEQ_W-1:KEEP_LO] == $past(seq_count[SEQ_W-1:KEEP_LO])));
        end
    endgenerate
endmodule

// File: tb/test_rx_desc_walker.sv
module test_rx_desc_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wide_mode = 1'b0;
    logic [15:0] upper_addr = 16'h00A5;
    logic        cfg_load = 1'b0;
    logic [15:0] cfg_ptr = '0;
    logic [15:0] cfg_seq = '0;
    logic [1:0]  irq_clr = '0;
    logic        pkt_arrive = 1'b0;
    logic        pkt_stored = 1'b0;
    logic        dec_valid, dec_accept, busy;
    logic        mem_req, mem_we, mem_done;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [15:0] cur_ptr, last_link, seq_count;
    logic        irq_rx, irq_exh;

    always #2.5 clk = ~clk;

    rx_desc_walker i_rx_desc_walker (
        .clk(clk), .rst(rst), .wide_mode(wide_mode), .upper_addr(upper_addr),
        .cfg_load(cfg_load), .cfg_ptr(cfg_ptr), .cfg_seq(cfg_seq), .irq_clr(irq_clr),
        .pkt_arrive(pkt_arrive), .pkt_stored(pkt_stored),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_done(mem_done),
        .cur_ptr(cur_ptr), .last_link(last_link), .seq_count(seq_count),
        .irq_rx(irq_rx), .irq_exh(irq_exh)
    );

    // model memory: 256 halfwords, little-endian long words
    logic [15:0] mem [0:255];
    logic [7:0]  idx;
    int          n_writes = 0;
    logic [31:0] last_rd_addr = '0;
    logic [31:0] last_wr_addr = '0;
    assign idx = mem_addr[8:1];

    initial mem_done = 1'b0;
    initial mem_rdata = '0;
    always @(posedge clk) begin
        if (rst) begin
            mem_done <= 1'b0;
        end else if (mem_req && !mem_done) begin
            mem_done <= 1'b1;
            if (mem_we) begin
                mem[idx] <= mem_wdata[15:0];
                if (wide_mode) mem[idx + 8'd1] <= mem_wdata[31:16];
                n_writes     <= n_writes + 1;
                last_wr_addr <= mem_addr;
            end else begin
                mem_rdata    <= {mem[idx + 8'd1], mem[idx]};
                last_rd_addr <= mem_addr;
            end
        end else begin
            mem_done <= 1'b0;
        end
    end

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic arrive(output logic acc);
        int t;
        acc = 1'bx;
        @(negedge clk) pkt_arrive = 1'b1;
        for (t = 0; t < 100; t++) begin
            @(negedge clk);
            pkt_arrive = 1'b0;
            if (dec_valid) begin
                acc = dec_accept;
                break;
            end
        end
        check_eq("R9 decision reported", {31'd0, (t < 100)}, 32'd1);
    endtask

    task automatic store_and_finish();
        @(negedge clk) pkt_stored = 1'b1;
        @(negedge clk) pkt_stored = 1'b0;
        for (int t = 0; t < 100; t++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        for (int t = 0; t < 100; t++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic load(input logic [15:0] p, input logic [15:0] s);
        @(negedge clk);
        cfg_ptr = p; cfg_seq = s; cfg_load = 1'b1;
        @(negedge clk) cfg_load = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk) irq_clr = 2'b11;
        @(negedge clk) irq_clr = 2'b00;
    endtask

    // {wide, pointer, link word}
    localparam logic [32:0] VEC [4] = '{
        {1'b0, 16'h0020, 16'h0040},
        {1'b0, 16'h0041, 16'h0061},
        {1'b1, 16'h0080, 16'h00C0},
        {1'b1, 16'h0100, 16'h0141}
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        logic acc;
        for (int k = 0; k < 256; k++) mem[k] = 16'h0000;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_eq("R1 cur_ptr", {16'd0, cur_ptr}, 32'd0);
        check_eq("R1 last_link", {16'd0, last_link}, 32'd0);
        check_eq("R1 seq_count", {16'd0, seq_count}, 32'd0);
        check_eq("R1 flags/busy/req", {28'd0, irq_rx, irq_exh, busy, mem_req}, 32'd0);

        // table walk: R2 R3 R4 R7 R8 R11
        for (int i = 0; i < 4; i++) begin
            logic        w;
            logic [15:0] p, l, b, lo, io, s0;
            w  = VEC[i][32];
            p  = VEC[i][31:16];
            l  = VEC[i][15:0];
            b  = {p[15:1], 1'b0};
            lo = w ? 16'd20 : 16'd10;
            io = w ? 16'd24 : 16'd12;
            s0 = {8'h34, 8'hF0 + 8'(i)};
            mem[(b + lo) >> 1]        = l;
            mem[((b + lo) >> 1) + 1]  = 16'hBEEF;
            mem[(b + io) >> 1]        = 16'hAAAA;
            mem[((b + io) >> 1) + 1]  = 16'h5555;
            wide_mode = w;
            load(p, s0);
            check_eq("R11 loaded pointer", {16'd0, cur_ptr}, {16'd0, p});
            arrive(acc);
            check_eq("R9 busy while waiting for store", {31'd0, busy}, 32'd1);
            check_eq("R4 accept on clean link", {31'd0, acc}, 32'd1);
            store_and_finish();
            check_eq("R2 link read address", last_rd_addr, {16'h00A5, b + lo});
            check_eq("R3 last_link loaded", {16'd0, last_link}, {16'd0, l});
            check_eq("R8 sequence bump", {16'd0, seq_count}, {16'd0, s0[15:8], s0[7:0] + 8'd1});
            if (l[0]) begin
                check_eq("R3 exhausted flags", {30'd0, irq_rx, irq_exh}, 32'd1);
                check_eq("R3 pointer held", {16'd0, cur_ptr}, {16'd0, p});
                check_eq("R3 in-use untouched", {16'd0, mem[(b + io) >> 1]}, 32'h0000AAAA);
            end else begin
                check_eq("R4 received flags", {30'd0, irq_rx, irq_exh}, 32'd2);
                check_eq("R4 pointer advanced", {16'd0, cur_ptr}, {16'd0, l});
                check_eq("R2 in-use write address", last_wr_addr, {16'h00A5, b + io});
                check_eq("R4 in-use cleared", {16'd0, mem[(b + io) >> 1]}, 32'd0);
                if (w) check_eq("R7 upper half zero", {16'd0, mem[((b + io) >> 1) + 1]}, 32'd0);
            end
            clear_flags();
        end

        // directed: hold, drop, host append, release (R5 R6 R8 wrap)
        begin
            int wr0;
            wide_mode = 1'b0;
            mem[8'h15] = 16'h0031;   // link of 0x20 at 0x2A: end of chain
            mem[8'h16] = 16'hAAAA;   // in-use of 0x20 at 0x2C
            load(16'h0020, 16'h12FF);
            arrive(acc);
            store_and_finish();
            check_eq("R8 low byte wraps", {16'd0, seq_count}, 32'h00001200);
            check_eq("R3 held at end", {16'd0, cur_ptr}, 32'h00000020);
            clear_flags();
            wr0 = n_writes;
            arrive(acc);
            wait_idle();
            check_eq("R5 drop when still end", {31'd0, acc}, 32'd0);
            check_eq("R5 no write on drop", n_writes, wr0);
            check_eq("R5 seq unchanged on drop", {16'd0, seq_count}, 32'h00001200);
            check_eq("R5 no flags on drop", {30'd0, irq_rx, irq_exh}, 32'd0);
            // host appends descriptor 0x50
            mem[8'h15] = 16'h0050;
            mem[8'h2D] = 16'h0070;   // link of 0x50 at 0x5A
            mem[8'h2E] = 16'hAAAA;   // in-use of 0x50 at 0x5C
            arrive(acc);
            check_eq("R6 accept after append", {31'd0, acc}, 32'd1);
            check_eq("R6 held descriptor released", {16'd0, mem[8'h16]}, 32'd0);
            check_eq("R6 pointer moved", {16'd0, cur_ptr}, 32'h00000050);
            check_eq("R6 received flag", {31'd0, irq_rx}, 32'd1);
            // R10: set wins over a same-cycle clear is not exercised; plain clear here
            @(negedge clk) irq_clr = 2'b01;
            @(negedge clk) irq_clr = 2'b00;
            check_eq("R10 rx flag cleared", {31'd0, irq_rx}, 32'd0);
            store_and_finish();
            check_eq("R4 second descriptor released", {16'd0, mem[8'h2E]}, 32'd0);
            check_eq("R4 pointer after append", {16'd0, cur_ptr}, 32'h00000070);
            check_eq("R8 seq after append", {16'd0, seq_count}, 32'h00001201);
            @(negedge clk) irq_clr = 2'b10;
            @(negedge clk) irq_clr = 2'b00;
            check_eq("R10 exh clear leaves rx", {30'd0, irq_rx, irq_exh}, 32'd2);
        end

        // reset again
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check_eq("R1 state after second reset", {14'd0, cur_ptr, irq_rx, busy}, 32'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule